// File: doc/BRIEF.md
# Vernier Interval Count Capture

This block is the digital counting and sequencing part of a two-oscillator vernier time quantizer. Once the start trigger is seen, every rising edge of the start-side oscillator clock lands in exactly one of three counters. The counter is chosen by how far the measurement has progressed. The first counter covers the span before the resolution switch. The second covers the span from the switch to the first coincidence of the two oscillators. The third, kept only for later noise estimation, covers the span from the first coincidence to the second coincidence. The interval itself is recovered from the first two counts alone.

The block also drives a select output that tells the oscillator pair to move from the wide coarse period spread to the narrow fine spread. It raises a one-cycle completion pulse when the second coincidence arrives. An active-high synchronous reset, clocked by the oscillator clock, prepares the block for each new sample. The three counts and their sum stay frozen from completion until that reset. The flag inputs can pass through an optional register chain, chosen by a parameter, when the detectors are not already synchronous to the count clock. The default has no chain.

Top module: `vernier_count_capture`

## Requirements
- R1: A clock edge with `rst` high clears all three counts, the three overflow bits, `done_o` and `spread_fine_o` in the following cycle.
- R2: While `trig_start_i` is low after reset, no edge is counted and the other flag inputs have no effect; the first counted edge is the first edge at which `trig_start_i` is seen high, and it counts into `pre_cnt_o`.
- R3: `pre_cnt_o` equals the number of edges from the start edge up to, but not including, the edge at which `res_switch_i` is first seen high.
- R4: `post_cnt_o` equals the number of edges from the switch edge up to, but not including, the edge at which `coinc1_i` is first seen high after the switch.
- R5: `nf_cnt_o` equals the number of edges from the first-coincidence edge up to, but not including, the edge at which `coinc2_i` is first seen high after it.
- R6: `coinc1_i` has no effect before the switch has been accepted, and `coinc2_i` has no effect before the first coincidence has been accepted.
- R7: `spread_fine_o` is low until the switch edge and high from the cycle after it until the next reset.
- R8: `done_o` is high for exactly the one cycle after the second-coincidence edge; afterwards all counts stay unchanged until reset, whatever the flags do.
- R9: `total_o` always equals `pre_cnt_o + post_cnt_o + nf_cnt_o`.
- R10: A count that is at 2^CNT_W-1 when one more edge falls into it stays at that value and sets its overflow bit (bit 0 for pre, bit 1 for post, bit 2 for noise); reaching exactly 2^CNT_W-1 does not set the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Start-side oscillator clock; every counted edge is a rising edge |
| rst | input | 1 | Synchronous active-high reset before each sample |
| trig_start_i | input | 1 | Start trigger seen (level, held high during the sample) |
| res_switch_i | input | 1 | Resolution switch indication from the detector |
| coinc1_i | input | 1 | First coincidence (end of conversion) |
| coinc2_i | input | 1 | Second coincidence (noise floor) |
| spread_fine_o | output | 1 | Selects the fine oscillator period spread |
| pre_cnt_o | output | CNT_W | Edges before the resolution switch |
| post_cnt_o | output | CNT_W | Edges from switch to first coincidence |
| nf_cnt_o | output | CNT_W | Edges from first to second coincidence |
| total_o | output | CNT_W+2 | Sum of the three counts |
| ovf_o | output | 3 | Saturation bits: pre, post, noise |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase state shows at the ports on the very next edge. An edge then goes into the wrong counter, so one count is one too high and its neighbour one too low when `done_o` fires. If the switch is accepted too early or too late, `spread_fine_o` moves on the wrong cycle. If a coincidence is accepted before it is armed, the segment before it is cut to one edge. A counter that wraps instead of saturating shows a small value with its overflow bit set. A missing freeze after completion shows as drifting counts within a cycle of the next flag change.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_PRE   = 3'd1,
      PH_POST  = 3'd2,
      PH_NOISE = 3'd3,
      PH_HOLD  = 3'd4
   } vic_phase_e;

   localparam int unsigned SEG_PRE   = 0;
   localparam int unsigned SEG_POST  = 1;
   localparam int unsigned SEG_NOISE = 2;
   localparam int unsigned NUM_SEG   = 3;

   localparam int unsigned FLG_START = 0;
   localparam int unsigned FLG_SW    = 1;
   localparam int unsigned FLG_C1    = 2;
   localparam int unsigned FLG_C2    = 3;
   localparam int unsigned NUM_FLG   = 4;

endpackage

// File: rtl/vic_flag_sync.sv
module vic_flag_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("vic_flag_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q[0] <= '0;
         end else begin
            stage_q[0] <= d_i;
         end
      end

      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               stage_q[s] <= '0;
            end else begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/vic_sat_counter.sv
module vic_sat_counter #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             ovf_o
);

   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_q;
   logic             ovf_q;
   logic             at_max;

   assign at_max = (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (inc_i) begin
         if (at_max) begin
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/vic_sequencer.sv
module vic_sequencer
   import vic_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_FLG-1:0] flg_i,
   output logic [NUM_SEG-1:0] inc_o,
   output logic               spread_fine_o,
   output logic               done_o
);

   vic_phase_e       phase_q, phase_d;
   logic [NUM_SEG-1:0] inc_d;
   logic             finish_d;
   logic             done_q;

   always_comb begin
      phase_d  = phase_q;
      inc_d    = '0;
      finish_d = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (flg_i[FLG_START]) begin
               phase_d        = PH_PRE;
               inc_d[SEG_PRE] = 1'b1;
            end
         end
         PH_PRE: begin
            if (flg_i[FLG_SW]) begin
               phase_d         = PH_POST;
               inc_d[SEG_POST] = 1'b1;
            end else begin
               inc_d[SEG_PRE] = 1'b1;
            end
         end
         PH_POST: begin
            if (flg_i[FLG_C1]) begin
               phase_d          = PH_NOISE;
               inc_d[SEG_NOISE] = 1'b1;
            end else begin
               inc_d[SEG_POST] = 1'b1;
            end
         end
         PH_NOISE: begin
            if (flg_i[FLG_C2]) begin
               phase_d  = PH_HOLD;
               finish_d = 1'b1;
            end else begin
               inc_d[SEG_NOISE] = 1'b1;
            end
         end
         PH_HOLD: begin
            phase_d = PH_HOLD;
         end
         default: begin
            phase_d = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= finish_d;
      end
   end

   assign inc_o         = rst ? '0 : inc_d;
   assign spread_fine_o = (phase_q == PH_POST) || (phase_q == PH_NOISE) ||
                          (phase_q == PH_HOLD);
   assign done_o        = done_q;

endmodule

// File: rtl/vernier_count_capture.sv
module vernier_count_capture
   import vic_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic                 clk_osc,
   input  logic                 rst,
   input  logic                 trig_start_i,
   input  logic                 res_switch_i,
   input  logic                 coinc1_i,
   input  logic                 coinc2_i,
   output logic                 spread_fine_o,
   output logic [CNT_W-1:0]     pre_cnt_o,
   output logic [CNT_W-1:0]     post_cnt_o,
   output logic [CNT_W-1:0]     nf_cnt_o,
   output logic [CNT_W+1:0]     total_o,
   output logic [NUM_SEG-1:0]   ovf_o,
   output logic                 done_o
);

   localparam int unsigned TOT_W = CNT_W + 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("vernier_count_capture: CNT_W must lie in 2..32");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("vernier_count_capture: SYNC_STAGES must not exceed 4");
   end

   logic [NUM_FLG-1:0] flg_raw;
   logic [NUM_FLG-1:0] flg_s;
   logic [NUM_SEG-1:0] seg_inc;
   logic [CNT_W-1:0]   seg_cnt [NUM_SEG];
   logic [NUM_SEG-1:0] seg_ovf;

   assign flg_raw[FLG_START] = trig_start_i;
   assign flg_raw[FLG_SW]    = res_switch_i;
   assign flg_raw[FLG_C1]    = coinc1_i;
   assign flg_raw[FLG_C2]    = coinc2_i;

   vic_flag_sync #(
      .WIDTH  (NUM_FLG),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk_osc),
      .rst (rst),
      .d_i (flg_raw),
      .q_o (flg_s)
   );

   vic_sequencer u_seq (
      .clk           (clk_osc),
      .rst           (rst),
      .flg_i         (flg_s),
      .inc_o         (seg_inc),
      .spread_fine_o (spread_fine_o),
      .done_o        (done_o)
   );

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      vic_sat_counter #(
         .WIDTH (CNT_W)
      ) u_cnt (
         .clk   (clk_osc),
         .rst   (rst),
         .inc_i (seg_inc[g]),
         .cnt_o (seg_cnt[g]),
         .ovf_o (seg_ovf[g])
      );
   end

   assign pre_cnt_o  = seg_cnt[SEG_PRE];
   assign post_cnt_o = seg_cnt[SEG_POST];
   assign nf_cnt_o   = seg_cnt[SEG_NOISE];
   assign ovf_o      = seg_ovf;
   assign total_o    = TOT_W'(seg_cnt[SEG_PRE]) + TOT_W'(seg_cnt[SEG_POST]) +
                       TOT_W'(seg_cnt[SEG_NOISE]);

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [2:0]       inc,
   input logic [CNT_W-1:0] pre,
   input logic [CNT_W-1:0] post,
   input logic [CNT_W-1:0] nf,
   input logic [2:0]       ovf,
   input logic             spread,
   input logic             done
);

   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   logic done_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         done_seen <= 1'b0;
      end else if (done) begin
         done_seen <= 1'b1;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (pre == '0 && post == '0 && nf == '0 && ovf == '0 && !done && !spread));

   assert_one_segment_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(inc));

   assert_pre_grows_R3: assert property (@(posedge clk) disable iff (rst)
      inc[0] |=> (pre != '0));

   assert_order_R6: assert property (@(posedge clk) disable iff (rst)
      (nf != '0) |-> (post != '0 && pre != '0));

   assert_spread_post_R7: assert property (@(posedge clk) disable iff (rst)
      (post != '0) |-> spread);

   assert_spread_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      spread |=> spread);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      done_seen |=> ($stable(pre) && $stable(post) && $stable(nf) && $stable(ovf)));

   assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
      (pre == FULL) |=> (pre == FULL));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      ovf[0] |=> ovf[0]);

endmodule

bind vernier_count_capture vic_checker #(
   .CNT_W (CNT_W)
) u_chk (
   .clk    (clk_osc),
   .rst    (rst),
   .inc    (seg_inc),
   .pre    (pre_cnt_o),
   .post   (post_cnt_o),
   .nf     (nf_cnt_o),
   .ovf    (ovf_o),
   .spread (spread_fine_o),
   .done   (done_o)
);

// File: tb/vernier_count_capture_tb.sv
module vernier_count_capture_tb;

   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;

   typedef struct {
      int pre;
      int post;
      int nf;
      int ovf;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst;
   logic         st, sw, c1, c2;
   logic         spread;
   logic [W-1:0] pre, post, nf;
   logic [W+1:0] total;
   logic [2:0]   ovf;
   logic         done;

   int n_cmp = 0;
   int n_bad = 0;
   int n_pushed = 0;
   int n_done = 0;
   int cycles = 0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   vernier_count_capture #(.CNT_W(W), .SYNC_STAGES(0)) u_dut (
      .clk_osc       (clk),
      .rst           (rst),
      .trig_start_i  (st),
      .res_switch_i  (sw),
      .coinc1_i      (c1),
      .coinc2_i      (c2),
      .spread_fine_o (spread),
      .pre_cnt_o     (pre),
      .post_cnt_o    (post),
      .nf_cnt_o      (nf),
      .total_o       (total),
      .ovf_o         (ovf),
      .done_o        (done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int sat(input int n);
      return (n > MAXV) ? MAXV : n;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; st = 1'b0; sw = 1'b0; c1 = 1'b0; c2 = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic check_cleared(input string tag);
      check(pre == 0 && post == 0 && nf == 0, tag, int'(total), 0);
      check(ovf == 3'b000 && !done && !spread, tag, int'({ovf, done, spread}), 0);
   endtask

   // Driver: pushes the expected result, then plays the flag sequence.
   task automatic run_meas(input int n1, input int n2, input int n3,
                           input bit early1, input bit early2);
      exp_t e;
      int   fp, fq, fn;
      e.pre  = sat(n1);
      e.post = sat(n2);
      e.nf   = sat(n3);
      e.ovf  = ((n1 > MAXV) ? 1 : 0) | ((n2 > MAXV) ? 2 : 0) | ((n3 > MAXV) ? 4 : 0);
      sb_q.push_back(e);
      n_pushed++;
      do_reset();
      st = 1'b1;
      if (early1) c1 = 1'b1;
      repeat (n1) @(negedge clk);
      check(!spread, "R7 spread before switch", int'(spread), 0);
      sw = 1'b1;
      if (early2) c2 = 1'b1;
      @(negedge clk);
      check(spread, "R7 spread after switch", int'(spread), 1);
      repeat (n2 - 1) @(negedge clk);
      c1 = 1'b1;
      repeat (n3) @(negedge clk);
      c2 = 1'b1;
      @(negedge clk);
      check(done, "R8 done raised", int'(done), 1);
      @(negedge clk);
      check(!done, "R8 done one cycle", int'(done), 0);
      fp = int'(pre); fq = int'(post); fn = int'(nf);
      for (int k = 0; k < 4; k++) begin
         c2 = ~c2; c1 = ~c1; sw = ~sw;
         @(negedge clk);
      end
      check(int'(pre) == fp && int'(post) == fq && int'(nf) == fn && !done,
            "R8 counts frozen", int'(pre) + int'(post) + int'(nf), fp + fq + fn);
      check(spread, "R7 spread held", int'(spread), 1);
   endtask

   // Monitor: pops and compares on each completion pulse.
   always @(negedge clk) begin
      if (!rst && done) begin
         n_done++;
         if (sb_q.size() == 0) begin
            check(1'b0, "R8 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(int'(pre) == e.pre, "R3 pre count", int'(pre), e.pre);
            check(int'(post) == e.post, "R4 post count", int'(post), e.post);
            check(int'(nf) == e.nf, "R5 noise count", int'(nf), e.nf);
            check(int'(total) == e.pre + e.post + e.nf, "R9 total", int'(total),
                  e.pre + e.post + e.nf);
            check(int'(ovf) == e.ovf, "R10 overflow bits", int'(ovf), e.ovf);
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      rst = 1'b1; st = 1'b0; sw = 1'b0; c1 = 1'b0; c2 = 1'b0;
      repeat (3) @(negedge clk);
      check_cleared("R1 reset state");
      rst = 1'b0;

      // R2: flags without start do nothing
      sw = 1'b1; c1 = 1'b1; c2 = 1'b1;
      repeat (10) @(negedge clk);
      check(pre == 0 && post == 0 && nf == 0 && !spread, "R2 idle without start",
            int'(total), 0);
      sw = 1'b0; c1 = 1'b0; c2 = 1'b0;
      st = 1'b1;
      @(negedge clk);
      check(pre == 1 && post == 0, "R2 first counted edge", int'(pre), 1);

      // R1: reset in mid-measurement
      repeat (5) @(negedge clk);
      sw = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_cleared("R1 mid-sample reset");
      rst = 1'b0; st = 1'b0; sw = 1'b0;

      run_meas(5, 7, 3, 1'b0, 1'b0);
      run_meas(1, 1, 1, 1'b0, 1'b0);
      run_meas(20, 3, 9, 1'b0, 1'b0);
      run_meas(4, 1, 6, 1'b1, 1'b0);   // R6: early first coincidence
      run_meas(6, 5, 1, 1'b0, 1'b1);   // R6: early second coincidence
      run_meas(MAXV, 2, 2, 1'b0, 1'b0); // R10: exactly full, no overflow
      run_meas(300, 4, 2, 1'b0, 1'b0);  // R10: pre saturates
      run_meas(2, 260, 1, 1'b0, 1'b0);  // R10: post saturates

      repeat (3) @(negedge clk);
      check(n_done == n_pushed && sb_q.size() == 0, "R8 done count", n_done, n_pushed);
      finish_run();
   end

endmodule